// File: doc/BRIEF.md
# Prioritized interrupt source encoder

This block gathers seven interrupt sources of a bus controller (error, three transmit buffers, two receive buffers and bus wake-up) into a single 3-bit interrupt code and one interrupt request line. Each source owns a sticky flag that hardware sets with a one-cycle pulse, and an enable bit that decides whether the flag takes part in the interrupt.

Software clears flags through per-source clear requests. A clear is refused while the hardware condition behind the flag is still present, so an interrupt cannot be dismissed before its cause has gone away. The gated sources are ranked in a fixed order, and the winner is mapped to an irregular code table. The code and the request line come from registers.

Top module: `irq_prio_encoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `flags_o`, `irq_code` and `irq_out` are all zero.
- R2: A 1 on `set_pulse[i]` at a rising edge makes `flags_o[i]` 1 after that edge. This holds even when `clr_req[i]` is 1 in the same cycle, because a set beats a clear.
- R3: A flag that is not cleared keeps its value. With no set pulse, a flag at 0 stays 0.
- R4: `clr_req[i]` has no effect while `hw_cond[i]` is 1. The flag stays 1.
- R5: `clr_req[i]` with `hw_cond[i]` at 0 and no set pulse makes `flags_o[i]` 0 after the edge.
- R6: Source i is active only when `flags_o[i]` and `enable[i]` are both 1. A disabled flag keeps its value but does not affect `irq_code` or `irq_out`.
- R7: `irq_code` is 000 when no source is active.
- R8: Bit index i selects the source: 0 error, 1 transmit 0, 2 transmit 1, 3 transmit 2, 4 receive 0, 5 receive 1, 6 wake. Priority runs from index 0 (highest) to index 6. The codes are: error 001, transmit 0 100, transmit 1 011, transmit 2 010, receive 0 110, receive 1 101, wake 111. A source's code appears only when every higher-priority source is inactive.
- R9: `irq_out` is 1 exactly when at least one source is active.
- R10: `irq_code` and `irq_out` are registered. After each edge they show the result for the flags and enables that were present just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 7 | Per-source hardware set pulses |
| hw_cond | input | 7 | Per-source hardware condition still present |
| clr_req | input | 7 | Per-source software clear requests |
| enable | input | 7 | Per-source interrupt enables |
| flags_o | output | 7 | Sticky flag vector |
| irq_code | output | 3 | Registered code of the highest-priority active source |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that all inputs are two-state and change only between clock edges. They make no assumption about how `hw_cond` relates to a flag: a flag whose condition is high must simply survive any clear. The stimulus drives every input one nanosecond after the rising edge. Random cycles draw `hw_cond`, `clr_req` and `enable` independently of the flags, which covers a wider space than the real usage, where a condition normally goes with a set flag. Set pulses are kept sparse so that clears have a chance to take effect.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int SRC_COUNT = 7;
  localparam int CODE_W    = 3;

  typedef enum int {
    SRC_ERR = 0, SRC_TX0 = 1, SRC_TX1 = 2, SRC_TX2 = 3,
    SRC_RX0 = 4, SRC_RX1 = 5, SRC_WAKE = 6
  } src_idx_e;

  // Code per priority slot; slot 0 is the highest priority.
  function automatic logic [CODE_W-1:0] slot_code(input int idx);
    case (idx)
      SRC_ERR:  slot_code = 3'b001;
      SRC_TX0:  slot_code = 3'b100;
      SRC_TX1:  slot_code = 3'b011;
      SRC_TX2:  slot_code = 3'b010;
      SRC_RX0:  slot_code = 3'b110;
      SRC_RX1:  slot_code = 3'b101;
      SRC_WAKE: slot_code = 3'b111;
      default:  slot_code = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = irq_enc_pkg::SRC_COUNT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_pulse,
  input  logic [N-1:0] hw_cond,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    logic clr_ok;
    assign clr_ok = clr_req[i] & ~hw_cond[i];

    always_ff @(posedge clk) begin
      if (rst)               flag_q <= 1'b0;
      else if (set_pulse[i]) flag_q <= 1'b1;
      else if (clr_ok)       flag_q <= 1'b0;
    end
    assign flags[i] = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_pulse[i] |=> flags[i]); // R2
    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && hw_cond[i]) |=> flags[i]); // R4
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && clr_req[i] && !hw_cond[i] && !set_pulse[i]) |=> !flags[i]); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      (!flags[i] && !set_pulse[i]) |=> !flags[i]); // R3
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int N  = irq_enc_pkg::SRC_COUNT,
  parameter int CW = irq_enc_pkg::CODE_W
) (
  input  logic [N-1:0]  gated,
  output logic [CW-1:0] code,
  output logic          any
);
  logic [N:0]   seen;
  logic [N-1:0] win;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | gated[i];
    assign win[i]    = gated[i] & ~seen[i];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++)
      if (win[i]) code = code | irq_enc_pkg::slot_code(i);
  end
  assign any = seen[N];
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int CW = irq_enc_pkg::CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] code_d,
  input  logic          any_d,
  output logic [CW-1:0] code_q,
  output logic          any_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      any_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      any_q  <= any_d;
    end
  end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] set_pulse,
  input  logic [6:0] hw_cond,
  input  logic [6:0] clr_req,
  input  logic [6:0] enable,
  output logic [6:0] flags_o,
  output logic [2:0] irq_code,
  output logic       irq_out
);
  localparam int N  = irq_enc_pkg::SRC_COUNT;
  localparam int CW = irq_enc_pkg::CODE_W;

  logic [N-1:0]  flags;
  logic [N-1:0]  gated;
  logic [CW-1:0] code_d;
  logic          any_d;

  irq_flag_bank #(.N(N)) u_bank (
    .clk(clk), .rst(rst), .set_pulse(set_pulse), .hw_cond(hw_cond),
    .clr_req(clr_req), .flags(flags)
  );

  assign gated = flags & enable;

  irq_prio_resolve #(.N(N), .CW(CW)) u_resolve (
    .gated(gated), .code(code_d), .any(any_d)
  );

  irq_out_stage #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .code_d(code_d), .any_d(any_d),
    .code_q(irq_code), .any_q(irq_out)
  );

  assign flags_o = flags;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|(flags_o & enable))); // R9
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    (irq_code == 3'b000) == !irq_out); // R7
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (rst)
    $past(flags_o[0] & enable[0]) |-> irq_code == 3'b001); // R8
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    $past(enable == 7'd0) |-> !irq_out); // R6
endmodule

// File: tb/irq_prio_encoder_bench.sv
`timescale 1ns/1ps
module irq_prio_encoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] set_pulse = '0, hw_cond = '0, clr_req = '0, enable = '0;
  logic [6:0] flags_o;
  logic [2:0] irq_code;
  logic       irq_out;

  int total = 0, bad = 0;
  logic [6:0] m_flags = '0;
  logic [2:0] m_code = '0;
  logic       m_irq = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_encoder u_irq_prio_encoder (
    .clk(clk), .rst(rst), .set_pulse(set_pulse), .hw_cond(hw_cond),
    .clr_req(clr_req), .enable(enable), .flags_o(flags_o),
    .irq_code(irq_code), .irq_out(irq_out)
  );

  function automatic logic [2:0] ref_code(input logic [6:0] act);
    if (act[0]) return 3'b001;
    if (act[1]) return 3'b100;
    if (act[2]) return 3'b011;
    if (act[3]) return 3'b010;
    if (act[4]) return 3'b110;
    if (act[5]) return 3'b101;
    if (act[6]) return 3'b111;
    return 3'b000;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic [6:0] nf;
    if (rst) begin
      nf = '0; m_code = '0; m_irq = 1'b0;
    end else begin
      m_code = ref_code(m_flags & enable);
      m_irq  = |(m_flags & enable);
      nf = set_pulse | (m_flags & ~(clr_req & ~hw_cond));
    end
    m_flags = nf;
    @(posedge clk); #1;
    chk({tag, " flags"}, flags_o, m_flags);
    chk({tag, " code"}, irq_code, m_code);
    chk({tag, " irq"}, irq_out, m_irq);
  endtask

  task automatic drive(input logic [6:0] s, input logic [6:0] c,
                       input logic [6:0] k, input logic [6:0] e);
    set_pulse = s; hw_cond = c; clr_req = k; enable = e;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    drive(7'h7f, 7'h00, 7'h00, 7'h7f);
    tick("R1 in reset");
    tick("R1 in reset");
    rst = 1'b0;
    drive('0, '0, '0, 7'h7f);
    tick("R1 after reset");

    // error and wake raised together: error wins with 001
    drive(7'h41, '0, '0, 7'h7f); tick("R2 set");
    drive('0, '0, '0, 7'h7f);    tick("R8 err over wake");
    chk("R8 err code", irq_code, 3'b001);
    // clear refused while condition present
    drive('0, 7'h01, 7'h01, 7'h7f); tick("R4 clr blocked");
    chk("R4 flag kept", flags_o[0], 1);
    drive('0, 7'h00, 7'h01, 7'h7f); tick("R5 clr ok");
    chk("R5 flag gone", flags_o[0], 0);
    drive('0, '0, '0, 7'h7f);    tick("R10 code follows");
    chk("R8 wake code", irq_code, 3'b111);
    // set and clear on the same cycle
    drive(7'h08, '0, 7'h08, 7'h7f); tick("R2 set beats clr");
    chk("R2 tx2 flag", flags_o[3], 1);
    drive('0, '0, '0, 7'h7f);       tick("R8 tx2");
    chk("R8 tx2 code", irq_code, 3'b010);
    // masking keeps flags but silences outputs
    drive('0, '0, '0, 7'h00); tick("R6 mask");
    tick("R6 mask settled");
    chk("R7 code idle", irq_code, 3'b000);
    chk("R6 flags kept", flags_o, 7'h48);
    chk("R9 irq low", irq_out, 0);
    // clear everything
    drive('0, '0, 7'h7f, 7'h00); tick("R5 clear all");
    chk("R5 all cleared", flags_o, 0);

    // exhaustive gating over all 128 enable patterns with every flag set
    drive(7'h7f, '0, '0, 7'h00); tick("R2 set all");
    for (int v = 0; v < 128; v++) begin
      drive('0, '0, '0, v[6:0]);
      tick("R8 exhaustive");
    end
    drive('0, '0, '0, 7'h00); tick("R10 exhaustive tail");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] s;
      s = 7'($urandom) & 7'($urandom) & 7'($urandom);
      drive(s, 7'($urandom), 7'($urandom), 7'($urandom));
      tick("R3 R9 random");
    end
    drive('0, '0, '0, '0); tick("R10 random tail");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule